// File: doc/BRIEF.md
# Multiprocessor-Bit Serial Transmitter

This block sends asynchronous serial frames on one output line. A host places a byte and a multiprocessor bit into a holding register with a single write strobe. That write also marks the holding register as full. On a bit-rate strobe, the transmitter copies the held byte into its own shift register and marks the holding register empty again. The host can then queue the next byte while the current frame is still going out. Each frame has four parts, in this order: a low start bit, seven or eight data bits with the least significant bit first, the multiprocessor bit, and one or two high stop bits.

At the end of the last stop bit the transmitter checks whether a new byte is waiting. If one is, the next start bit follows with no gap. If none is, the block raises a transmit-end flag and holds the line high. There are two interrupt outputs. Each one, when its enable is set, follows either the empty flag or the transmit-end flag. Bit timing comes entirely from a one-clock-wide strobe input, so the bit rate is set outside the block.

Top module: `mp_uart_tx`

## Requirements
- R1: After reset the line `tx_out` is 1, `empty_flag` is 1, `tend_flag` is 1, and both interrupt outputs are 0 while their enables are 0.
- R2: A cycle with `hold_wr` high stores `hold_data` and `hold_mpb`. From the next cycle `empty_flag` and `tend_flag` read 0.
- R3: A frame is loaded at a strobe cycle (`baud_en` high) in which the line is idle or the last stop bit is ending, and `empty_flag` is 0. From the next cycle `tx_out` is 0 (the start bit) and `empty_flag` is 1.
- R4: After the start bit, `tx_out` carries the data bits LSB first, then the stored multiprocessor bit, then the stop bits at 1. Each bit lasts from one strobe to the next, and `tx_out` changes only in the cycle after a strobe.
- R5: With `cfg_len7`=1 at load, only data bits 0 to 6 are sent, and bit 7 has no effect on the line.
- R6: With `cfg_stop2`=1 at load, two stop bits are sent; with 0, one stop bit is sent.
- R7: `cfg_len7` and `cfg_stop2` are sampled only at load. Changing them during a frame does not change that frame.
- R8: If `empty_flag` is 0 at the strobe that ends the last stop bit, the next start bit begins at once and `tend_flag` stays 0.
- R9: If `empty_flag` is 1 at the strobe that ends the last stop bit, `tend_flag` rises and `tx_out` stays 1 until a new frame is loaded.
- R10: `txe_irq` equals `txe_ie` AND `empty_flag`, and `tend_irq` equals `tend_ie` AND `tend_flag`.
- R11: If a host write lands in the same cycle as a load, the old byte is sent, the new byte is kept, and `empty_flag` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_en | input | 1 | One-cycle bit-period strobe |
| hold_wr | input | 1 | Host write of the holding register; marks it full |
| hold_data | input | DATA_W | Byte to send |
| hold_mpb | input | 1 | Multiprocessor bit for the frame being written |
| cfg_len7 | input | 1 | 1 selects one data bit fewer than DATA_W |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| txe_ie | input | 1 | Data-empty interrupt enable |
| tend_ie | input | 1 | Transmit-end interrupt enable |
| tx_out | output | 1 | Serial line, idle high |
| empty_flag | output | 1 | Holding register holds no unsent byte |
| tend_flag | output | 1 | Transmission finished, line at mark |
| txe_irq | output | 1 | Data-empty interrupt request |
| tend_irq | output | 1 | Transmit-end interrupt request |

## Verification
Single isolated frames show the bit order and the multiprocessor-bit slot. Frames in seven-bit and two-stop-bit modes, sent with a strobe every cycle, separate the length and stop-count options from the default mode. Three bytes written one after another as soon as the empty flag rises show whether frames chain with no idle gap. A configuration change during a frame, and a write that lands in the same cycle as a load, test when configuration is sampled and which of two simultaneous updates wins.

// File: rtl/mptx_pkg.sv
package mptx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_MPB,
        ST_STOP
    } tx_state_e;
endpackage

// File: rtl/mptx_holding.sv
module mptx_holding #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              wmpb_i,
    input  logic              load_i,
    input  logic              end_i,
    output logic [DATA_W-1:0] data_o,
    output logic              mpb_o,
    output logic              empty_o,
    output logic              tend_o
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              mpb;
        logic              empty;
        logic              tend;
    } hold_s;

    hold_s hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (load_i) hold_d.empty = 1'b1;
        if (end_i)  hold_d.tend  = 1'b1;
        // a host write takes priority over a load or an end in the same cycle
        if (wr_i) begin
            hold_d.data  = wdata_i;
            hold_d.mpb   = wmpb_i;
            hold_d.empty = 1'b0;
            hold_d.tend  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q.data  <= '0;
            hold_q.mpb   <= 1'b0;
            hold_q.empty <= 1'b1;
            hold_q.tend  <= 1'b1;
        end else begin
            hold_q <= hold_d;
        end
    end

    assign data_o  = hold_q.data;
    assign mpb_o   = hold_q.mpb;
    assign empty_o = hold_q.empty;
    assign tend_o  = hold_q.tend;
endmodule

// File: rtl/mptx_shifter.sv
module mptx_shifter
    import mptx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_i,
    input  logic              full_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              mpb_i,
    input  logic              short_i,
    input  logic              stop2_i,
    output logic              load_o,
    output logic              end_o,
    output logic              tx_o
);
    localparam int CNT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(DATA_W - 2);

    typedef struct packed {
        tx_state_e         state;
        logic [DATA_W-1:0] shift;
        logic [CNT_W-1:0]  cnt;
        logic              mpb;
        logic              stop2;
        logic              stop_left;
        logic              tx;
    } shf_s;

    shf_s sh_d, sh_q;
    logic do_load;

    always_comb begin
        sh_d    = sh_q;
        do_load = 1'b0;
        end_o   = 1'b0;
        if (baud_i) begin
            case (sh_q.state)
                ST_IDLE: begin
                    if (full_i) do_load = 1'b1;
                end
                ST_START: begin
                    sh_d.state = ST_DATA;
                    sh_d.tx    = sh_q.shift[0];
                    sh_d.shift = sh_q.shift >> 1;
                end
                ST_DATA: begin
                    if (sh_q.cnt == '0) begin
                        sh_d.state = ST_MPB;
                        sh_d.tx    = sh_q.mpb;
                    end else begin
                        sh_d.tx    = sh_q.shift[0];
                        sh_d.shift = sh_q.shift >> 1;
                        sh_d.cnt   = sh_q.cnt - 1'b1;
                    end
                end
                ST_MPB: begin
                    sh_d.state     = ST_STOP;
                    sh_d.tx        = 1'b1;
                    sh_d.stop_left = sh_q.stop2;
                end
                ST_STOP: begin
                    if (sh_q.stop_left) begin
                        sh_d.stop_left = 1'b0;
                    end else if (full_i) begin
                        do_load = 1'b1;
                    end else begin
                        sh_d.state = ST_IDLE;
                        sh_d.tx    = 1'b1;
                        end_o      = 1'b1;
                    end
                end
                default: begin
                    sh_d.state = ST_IDLE;
                    sh_d.tx    = 1'b1;
                end
            endcase
        end
        if (do_load) begin
            sh_d.state     = ST_START;
            sh_d.tx        = 1'b0;
            sh_d.shift     = data_i;
            sh_d.mpb       = mpb_i;
            sh_d.stop2     = stop2_i;
            sh_d.stop_left = 1'b0;
            sh_d.cnt       = short_i ? LAST_SHORT : LAST_LONG;
        end
        load_o = do_load;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q.state     <= ST_IDLE;
            sh_q.shift     <= '0;
            sh_q.cnt       <= '0;
            sh_q.mpb       <= 1'b0;
            sh_q.stop2     <= 1'b0;
            sh_q.stop_left <= 1'b0;
            sh_q.tx        <= 1'b1;
        end else begin
            sh_q <= sh_d;
        end
    end

    assign tx_o = sh_q.tx;
endmodule

// File: rtl/mp_uart_tx.sv
module mp_uart_tx #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              baud_en,
    input  logic              hold_wr,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_mpb,
    input  logic              cfg_len7,
    input  logic              cfg_stop2,
    input  logic              txe_ie,
    input  logic              tend_ie,
    output logic              tx_out,
    output logic              empty_flag,
    output logic              tend_flag,
    output logic              txe_irq,
    output logic              tend_irq
);
    logic [DATA_W-1:0] held_data;
    logic              held_mpb;
    logic              load_pulse;
    logic              end_pulse;
    logic              empty_w;
    logic              tend_w;

    mptx_holding #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (hold_wr),
        .wdata_i (hold_data),
        .wmpb_i  (hold_mpb),
        .load_i  (load_pulse),
        .end_i   (end_pulse),
        .data_o  (held_data),
        .mpb_o   (held_mpb),
        .empty_o (empty_w),
        .tend_o  (tend_w)
    );

    mptx_shifter #(.DATA_W(DATA_W)) u_shf (
        .clk     (clk),
        .rst_n   (rst_n),
        .baud_i  (baud_en),
        .full_i  (!empty_w),
        .data_i  (held_data),
        .mpb_i   (held_mpb),
        .short_i (cfg_len7),
        .stop2_i (cfg_stop2),
        .load_o  (load_pulse),
        .end_o   (end_pulse),
        .tx_o    (tx_out)
    );

    assign empty_flag = empty_w;
    assign tend_flag  = tend_w;
    assign txe_irq    = txe_ie && empty_w;
    assign tend_irq   = tend_ie && tend_w;
endmodule

// File: rtl/mptx_chk.sv
module mptx_chk (
    input logic clk,
    input logic rst_n,
    input logic baud_en,
    input logic hold_wr,
    input logic tx_out,
    input logic empty_flag,
    input logic tend_flag
);
    // R2: a host write empties neither flag slot: both read 0 next cycle
    a_r2_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
        hold_wr |=> (!empty_flag && !tend_flag));

    // R3: the empty flag only rises at a load, which starts a low start bit
    a_r3_load_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(empty_flag) |-> !tx_out);

    // R4: the line moves only after a strobe
    a_r4_line_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_en |=> $stable(tx_out));

    // R9: transmit-end means the line sits at mark
    a_r9_tend_mark: assert property (@(posedge clk) disable iff (!rst_n)
        tend_flag |-> tx_out);

    // R9: transmit-end only rises at the end of a stop bit
    a_r9_tend_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tend_flag) |-> $past(baud_en));
endmodule

bind mp_uart_tx mptx_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .baud_en    (baud_en),
    .hold_wr    (hold_wr),
    .tx_out     (tx_out),
    .empty_flag (empty_flag),
    .tend_flag  (tend_flag)
);

// File: tb/mp_uart_tx_tb.sv
module mp_uart_tx_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       baud_en = 1'b0;
    logic       hold_wr = 1'b0;
    logic [7:0] hold_data = 8'h00;
    logic       hold_mpb = 1'b0;
    logic       cfg_len7 = 1'b0;
    logic       cfg_stop2 = 1'b0;
    logic       txe_ie = 1'b0;
    logic       tend_ie = 1'b0;
    logic       tx_out, empty_flag, tend_flag, txe_irq, tend_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string tx_tag = "R4";

    always #5 clk = ~clk;

    mp_uart_tx #(.DATA_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .baud_en(baud_en), .hold_wr(hold_wr),
        .hold_data(hold_data), .hold_mpb(hold_mpb), .cfg_len7(cfg_len7),
        .cfg_stop2(cfg_stop2), .txe_ie(txe_ie), .tend_ie(tend_ie),
        .tx_out(tx_out), .empty_flag(empty_flag), .tend_flag(tend_flag),
        .txe_irq(txe_irq), .tend_irq(tend_irq)
    );

    // strobe generator
    int  bper = 4;
    int  bcnt = 0;
    bit  man_baud = 1'b0;
    always @(negedge clk) begin
        if (!man_baud) begin
            baud_en = (bcnt == 0);
            bcnt = (bcnt + 1 >= bper) ? 0 : bcnt + 1;
        end
    end

    // behavioural reference model
    bit       m_tx = 1'b1, m_empty = 1'b1, m_tend = 1'b1, m_busy = 1'b0;
    bit [7:0] m_hold = '0;
    bit       m_hmpb = 1'b0;
    bit       mq[$];
    always @(posedge clk) begin
        if (!rst_n) begin
            m_tx = 1'b1; m_empty = 1'b1; m_tend = 1'b1; m_busy = 1'b0;
            mq.delete();
        end else begin
            if (baud_en) begin
                if (mq.size() > 0) begin
                    m_tx = mq.pop_front();
                end else if (!m_empty) begin
                    m_tx = 1'b0;
                    for (int i = 0; i < (cfg_len7 ? 7 : 8); i++) mq.push_back(m_hold[i]);
                    mq.push_back(m_hmpb);
                    mq.push_back(1'b1);
                    if (cfg_stop2) mq.push_back(1'b1);
                    m_empty = 1'b1;
                    m_busy = 1'b1;
                end else if (m_busy) begin
                    m_busy = 1'b0;
                    m_tend = 1'b1;
                    m_tx = 1'b1;
                end
            end
            if (hold_wr) begin
                m_hold = hold_data; m_hmpb = hold_mpb;
                m_empty = 1'b0; m_tend = 1'b0;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the clock edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            #1;
            chk(tx_out === m_tx, tx_tag, int'(tx_out), int'(m_tx));
            chk(empty_flag === m_empty, "R3 empty flag", int'(empty_flag), int'(m_empty));
            chk(tend_flag === m_tend, "R9 tend flag", int'(tend_flag), int'(m_tend));
            chk(txe_irq === (txe_ie & m_empty), "R10 txe_irq", int'(txe_irq), int'(txe_ie & m_empty));
            chk(tend_irq === (tend_ie & m_tend), "R10 tend_irq", int'(tend_irq), int'(tend_ie & m_tend));
        end
    end

    task automatic wr(input logic [7:0] d, input logic mp);
        @(negedge clk);
        hold_wr = 1'b1; hold_data = d; hold_mpb = mp;
        @(negedge clk);
        hold_wr = 1'b0;
    endtask

    task automatic wait_empty();
        while (empty_flag !== 1'b1) @(negedge clk);
    endtask

    task automatic wait_tend();
        while (tend_flag !== 1'b1) @(negedge clk);
        repeat (6) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual 1 expected 0 (run hung)");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #2;
        // R1: reset state
        chk(tx_out === 1'b1, "R1 tx", int'(tx_out), 1);
        chk(empty_flag === 1'b1, "R1 empty", int'(empty_flag), 1);
        chk(tend_flag === 1'b1, "R1 tend", int'(tend_flag), 1);
        chk(txe_irq === 1'b0 && tend_irq === 1'b0, "R1 irqs", int'(txe_irq | tend_irq), 0);

        // R2 R3 R4: single eight-bit frame, one stop bit
        tx_tag = "R4 line";
        wr(8'hA5, 1'b1);
        #2 chk(empty_flag === 1'b0 && tend_flag === 1'b0, "R2 after write",
               int'({empty_flag, tend_flag}), 0);
        wait_tend();

        // R5 R6: seven-bit, two stop bits, strobe every cycle
        tx_tag = "R5/R6 line";
        bper = 1; cfg_len7 = 1'b1; cfg_stop2 = 1'b1;
        wr(8'hC3, 1'b0);
        wait_tend();
        wr(8'h7E, 1'b1);
        wait_tend();
        cfg_len7 = 1'b0; cfg_stop2 = 1'b0;

        // R8 R10: chained frames with interrupts enabled
        tx_tag = "R8 line";
        bper = 3; txe_ie = 1'b1; tend_ie = 1'b1;
        wr(8'h12, 1'b1);
        wait_empty();
        wr(8'h34, 1'b0);
        wait_empty();
        wr(8'h56, 1'b1);
        wait_tend();
        #2 chk(tend_irq === 1'b1, "R10 tend_irq at end", int'(tend_irq), 1);

        // R7: configuration changed in mid-frame
        tx_tag = "R7 line";
        bper = 5;
        wr(8'h9A, 1'b1);
        wait_empty();
        repeat (12) @(negedge clk);
        cfg_len7 = 1'b1; cfg_stop2 = 1'b1;
        wait_tend();
        cfg_len7 = 1'b0; cfg_stop2 = 1'b0;

        // R11: write in the same cycle as a load
        tx_tag = "R11 line";
        @(negedge clk);
        man_baud = 1'b1; baud_en = 1'b0;
        wr(8'h3C, 1'b0);
        @(negedge clk);
        hold_wr = 1'b1; hold_data = 8'h5A; hold_mpb = 1'b1; baud_en = 1'b1;
        @(negedge clk);
        hold_wr = 1'b0; baud_en = 1'b0;
        #2 chk(empty_flag === 1'b0, "R11 empty stays 0", int'(empty_flag), 0);
        chk(tx_out === 1'b0, "R11 start bit", int'(tx_out), 0);
        man_baud = 1'b0; bper = 2;
        wait_tend();

        txe_ie = 1'b0; tend_ie = 1'b0;
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule